// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides, at the moment a cache-block management or cache-block zero instruction issues, whether the current privilege context may execute it. It reads the privilege level, the virtualization flag and three environment-configuration words: one owned by machine mode, one by the hypervisor and one by the supervisor. It selects the enable field that matches the requested operation class and applies a three-level priority gate. The result is either permission or an exception with its cause: illegal instruction or virtual instruction.

Alongside the verdict the block presents the effective address rounded down to the start of its cache block. The block size is a power-of-two parameter. The request is sampled on a valid strobe. The verdict, the cause and the aligned address are registered and appear one cycle later together with a single-cycle done pulse. Memory writes, translation, page and physical-protection checks and any cache state are handled elsewhere.

Top module: `cbo_perm_check`

## Requirements
- R1: While reset is high and on the first cycle after it, `rsp_done`, `rsp_allow` and `rsp_exc` are 0, `rsp_cause` is 0 and `rsp_addr` is 0.
- R2: `rsp_done` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 otherwise.
- R3: The enable field is chosen by `req_op` and read from each configuration word.
  - 0 (zero) reads bit 7.
  - 1 (clean/flush) reads bit 6.
  - 2 and 3 (invalidate) read bits 5:4, where any nonzero value enables.
  - All other bits are ignored.
- R4: Privilege is encoded U=0, S=1, M=3 and compared numerically. If privilege is below 3 and the machine word's field is clear, the result is an exception with cause 2, whatever the other inputs are.
- R5: Otherwise, the result is an exception with cause 22 when `req_virt` is 1 and either of these holds:
  - privilege is at most 1 and the hypervisor field is clear;
  - privilege is 0 and the supervisor field is clear.
- R6: Otherwise, if privilege is 0 and the supervisor field is clear, the result is an exception with cause 2.
- R7: A request at privilege 3 is always allowed, for any configuration word, operation and virtualization flag.
- R8: On every done cycle exactly one of `rsp_allow` and `rsp_exc` is 1. `rsp_cause` is 0 whenever the request was allowed.
- R9: `rsp_addr` equals the sampled `req_addr` with its low log2(BLK_BYTES) bits cleared.
- R10: In cycles without a request, `rsp_allow`, `rsp_exc`, `rsp_cause` and `rsp_addr` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| req_virt | input | 1 | Virtualization active |
| req_op | input | 2 | Operation class: 0 zero, 1 clean/flush, 2/3 invalidate |
| cfg_mach | input | CFG_W | Machine environment-configuration word |
| cfg_hyp | input | CFG_W | Hypervisor environment-configuration word |
| cfg_sup | input | CFG_W | Supervisor environment-configuration word |
| req_addr | input | ADDR_W | Effective address |
| rsp_done | output | 1 | One-cycle pulse marking a fresh verdict |
| rsp_allow | output | 1 | Operation permitted |
| rsp_exc | output | 1 | Operation raises an exception |
| rsp_cause | output | 5 | Exception cause (2 or 22), 0 when allowed |
| rsp_addr | output | ADDR_W | Block-aligned address |

## Verification
Every result of this block is due exactly one clock edge after the strobe that carried its request. This holds for the done pulse, the verdict, the cause and the aligned address alike, and none of them takes a second cycle. The bench drives requests on the falling edge. A behavioural model advances on the same rising edge that the design samples. All outputs are compared with the model on the falling edge that follows, so each verdict is checked in the cycle it first appears. Idle cycles are compared as well, which covers the absence of a done pulse and the holding of the previous verdict.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        OP_ZERO      = 2'd0,
        OP_CLEAN     = 2'd1,
        OP_INVAL     = 2'd2,
        OP_INVAL_ALT = 2'd3
    } cbop_e;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'd22;

    // Enable field positions inside every configuration word
    localparam int FLD_INV_LO = 4;
    localparam int FLD_INV_HI = 5;
    localparam int FLD_CLEAN  = 6;
    localparam int FLD_ZERO   = 7;
    localparam int FLD_SPAN   = 8;

    // Number of configuration levels (machine, hypervisor, supervisor)
    localparam int NUM_LVL = 3;
    localparam int LVL_M   = 0;
    localparam int LVL_H   = 1;
    localparam int LVL_S   = 2;

    typedef struct packed {
        logic m_en;
        logic h_en;
        logic s_en;
    } lvl_en_t;

    typedef struct packed {
        logic               allow;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
    } verdict_t;

    function automatic logic field_on(input logic [FLD_SPAN-1:0] low, input cbop_e op);
        logic r;
        unique case (op)
            OP_ZERO:  r = low[FLD_ZERO];
            OP_CLEAN: r = low[FLD_CLEAN];
            default:  r = |low[FLD_INV_HI:FLD_INV_LO];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cbo_field_pick.sv
module cbo_field_pick
    import cbo_perm_pkg::*;
#(
    parameter int CFG_W = 64
) (
    input  logic [CFG_W-1:0] cfg,
    input  cbop_e            op,
    output logic             en
);
    logic unused_hi;
    assign unused_hi = ^cfg[CFG_W-1:FLD_SPAN];

    always_comb begin
        en = field_on(cfg[FLD_SPAN-1:0], op);
    end
endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
    import cbo_perm_pkg::*;
(
    input  priv_e    priv,
    input  logic     virt,
    input  lvl_en_t  lvl,
    output verdict_t verdict
);
    logic below_m, at_or_below_s, below_s;

    always_comb begin
        below_m       = (priv < PRIV_M);
        at_or_below_s = (priv <= PRIV_S);
        below_s       = (priv < PRIV_S);

        verdict = '{allow: 1'b1, exc: 1'b0, cause: CAUSE_NONE};
        if (below_m && !lvl.m_en) begin
            verdict = '{allow: 1'b0, exc: 1'b1, cause: CAUSE_ILLEGAL};
        end else if (virt && ((at_or_below_s && !lvl.h_en) || (below_s && !lvl.s_en))) begin
            verdict = '{allow: 1'b0, exc: 1'b1, cause: CAUSE_VIRT};
        end else if (below_s && !lvl.s_en) begin
            verdict = '{allow: 1'b0, exc: 1'b1, cause: CAUSE_ILLEGAL};
        end
    end
endmodule

// File: rtl/cbo_align.sv
module cbo_align #(
    parameter int ADDR_W    = 64,
    parameter int BLK_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int OFS_W = $clog2(BLK_BYTES);

    generate
        if (OFS_W == 0) begin : g_byte_blocks
            assign addr_out = addr_in;
        end else begin : g_mask
            logic unused_ofs;
            assign unused_ofs = ^addr_in[OFS_W-1:0];
            assign addr_out   = {addr_in[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
    import cbo_perm_pkg::*;
#(
    parameter int CFG_W     = 64,
    parameter int ADDR_W    = 64,
    parameter int BLK_BYTES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_priv,
    input  logic                req_virt,
    input  logic [1:0]          req_op,
    input  logic [CFG_W-1:0]    cfg_mach,
    input  logic [CFG_W-1:0]    cfg_hyp,
    input  logic [CFG_W-1:0]    cfg_sup,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                rsp_done,
    output logic                rsp_allow,
    output logic                rsp_exc,
    output logic [CAUSE_W-1:0]  rsp_cause,
    output logic [ADDR_W-1:0]   rsp_addr
);
    logic [CFG_W-1:0] cfg_arr [NUM_LVL];
    logic [NUM_LVL-1:0] en_vec;
    lvl_en_t  lvl;
    verdict_t verdict;
    logic [ADDR_W-1:0] aligned;

    assign cfg_arr[LVL_M] = cfg_mach;
    assign cfg_arr[LVL_H] = cfg_hyp;
    assign cfg_arr[LVL_S] = cfg_sup;

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
            cbo_field_pick #(.CFG_W(CFG_W)) u_pick (
                .cfg (cfg_arr[g]),
                .op  (cbop_e'(req_op)),
                .en  (en_vec[g])
            );
        end
    endgenerate

    assign lvl = '{m_en: en_vec[LVL_M], h_en: en_vec[LVL_H], s_en: en_vec[LVL_S]};

    cbo_gate u_gate (
        .priv    (priv_e'(req_priv)),
        .virt    (req_virt),
        .lvl     (lvl),
        .verdict (verdict)
    );

    cbo_align #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_align (
        .addr_in  (req_addr),
        .addr_out (aligned)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_exc   <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_addr  <= '0;
        end else begin
            rsp_done <= req_valid;
            if (req_valid) begin
                rsp_allow <= verdict.allow;
                rsp_exc   <= verdict.exc;
                rsp_cause <= verdict.cause;
                rsp_addr  <= aligned;
            end
        end
    end
endmodule

// File: rtl/cbo_perm_check_sva.sv
module cbo_perm_check_sva #(
    parameter int ADDR_W    = 64,
    parameter int BLK_BYTES = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_priv,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_done,
    input logic              rsp_allow,
    input logic              rsp_exc,
    input logic [4:0]        rsp_cause,
    input logic [ADDR_W-1:0] rsp_addr
);
    localparam int OFS_W = $clog2(BLK_BYTES);

    a_r2_done_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);

    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_done);

    a_r8_one_verdict: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (rsp_allow != rsp_exc));

    a_r8_allowed_no_cause: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_allow) |-> (rsp_cause == 5'd0));

    a_r4_known_cause: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_exc) |-> (rsp_cause == 5'd2 || rsp_cause == 5'd22));

    a_r7_machine_allowed: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == 2'd3) |=> rsp_allow);

    a_r9_upper_kept: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ((rsp_addr >> OFS_W) == ($past(req_addr) >> OFS_W)));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_allow) && $stable(rsp_cause) && $stable(rsp_addr)));
endmodule

bind cbo_perm_check cbo_perm_check_sva #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_priv  (req_priv),
    .req_addr  (req_addr),
    .rsp_done  (rsp_done),
    .rsp_allow (rsp_allow),
    .rsp_exc   (rsp_exc),
    .rsp_cause (rsp_cause),
    .rsp_addr  (rsp_addr)
);

// File: tb/tb_cbo_perm_check.sv
`timescale 1ns/1ps
module tb_cbo_perm_check;
    localparam int CFG_W = 64;
    localparam int ADDR_W = 64;
    localparam int BLK_BYTES = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_priv = '0;
    logic req_virt = 1'b0;
    logic [1:0] req_op = '0;
    logic [CFG_W-1:0] cfg_mach = '0, cfg_hyp = '0, cfg_sup = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic rsp_done, rsp_allow, rsp_exc;
    logic [4:0] rsp_cause;
    logic [ADDR_W-1:0] rsp_addr;

    always #2.5 clk = ~clk;

    cbo_perm_check #(.CFG_W(CFG_W), .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_priv(req_priv),
        .req_virt(req_virt), .req_op(req_op), .cfg_mach(cfg_mach),
        .cfg_hyp(cfg_hyp), .cfg_sup(cfg_sup), .req_addr(req_addr),
        .rsp_done(rsp_done), .rsp_allow(rsp_allow), .rsp_exc(rsp_exc),
        .rsp_cause(rsp_cause), .rsp_addr(rsp_addr)
    );

    integer n_cmp = 0;
    integer n_bad = 0;
    integer cyc = 0;
    bit finished = 0;
    string tag = "R1";

    // Behavioural reference state
    logic m_done = 0, m_allow = 0, m_exc = 0;
    logic [4:0] m_cause = 0;
    logic [ADDR_W-1:0] m_addr = 0;

    function automatic bit fld(input logic [CFG_W-1:0] w, input logic [1:0] op);
        if (op == 2'd0) return w[7];
        if (op == 2'd1) return w[6];
        return (w[5:4] != 2'b00);
    endfunction

    function automatic integer ref_cause(input logic [1:0] pv, input logic vt, input logic [1:0] op,
                                         input logic [CFG_W-1:0] mw, input logic [CFG_W-1:0] hw,
                                         input logic [CFG_W-1:0] sw);
        integer p = pv;
        if (p < 3 && !fld(mw, op)) return 2;
        if (vt && ((p <= 1 && !fld(hw, op)) || (p == 0 && !fld(sw, op)))) return 22;
        if (p == 0 && !fld(sw, op)) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_done <= 0; m_allow <= 0; m_exc <= 0; m_cause <= 0; m_addr <= 0;
        end else begin
            m_done <= req_valid;
            if (req_valid) begin
                integer c;
                c = ref_cause(req_priv, req_virt, req_op, cfg_mach, cfg_hyp, cfg_sup);
                m_allow <= (c == 0);
                m_exc   <= (c != 0);
                m_cause <= c[4:0];
                m_addr  <= (req_addr / BLK_BYTES) * BLK_BYTES;
            end
        end
    end

    task automatic cmp(input string what, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            cmp("done",  {63'd0, rsp_done},  {63'd0, m_done});
            cmp("allow", {63'd0, rsp_allow}, {63'd0, m_allow});
            cmp("exc",   {63'd0, rsp_exc},   {63'd0, m_exc});
            cmp("cause", {59'd0, rsp_cause}, {59'd0, m_cause});
            cmp("addr",  rsp_addr, m_addr);
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<200000", cyc);
            finish_run();
        end
    end

    function automatic logic [CFG_W-1:0] mk(input bit z, input bit c, input logic [1:0] inv,
                                            input logic [CFG_W-1:0] junk);
        logic [CFG_W-1:0] w;
        w = junk;
        w[7] = z; w[6] = c; w[5:4] = inv;
        return w;
    endfunction

    task automatic issue(input string t, input logic [1:0] pv, input logic vt, input logic [1:0] op,
                         input logic [CFG_W-1:0] mw, input logic [CFG_W-1:0] hw,
                         input logic [CFG_W-1:0] sw, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        tag = t;
        req_valid = 1; req_priv = pv; req_virt = vt; req_op = op;
        cfg_mach = mw; cfg_hyp = hw; cfg_sup = sw; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        req_addr = {$urandom, $urandom};
        req_priv = 2'($urandom); req_op = 2'($urandom);
    endtask

    localparam logic [CFG_W-1:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [CFG_W-1:0] NONE = 64'h0;

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R7: machine mode with every field clear
        issue("R7", 2'd3, 1'b1, 2'd0, NONE, NONE, NONE, 64'h1234_5678_9ABC_DEF7);
        issue("R7", 2'd3, 1'b0, 2'd2, NONE, NONE, NONE, 64'h0000_0000_0000_003F);
        // R4: machine field clear wins over virtualization
        issue("R4", 2'd0, 1'b1, 2'd1, ~mk(0,1,0,0), NONE, NONE, 64'h40);
        issue("R4", 2'd1, 1'b1, 2'd0, mk(0,1,2'b11,ALL), ALL, ALL, 64'h41);
        // R5: virtual-instruction cases
        issue("R5", 2'd1, 1'b1, 2'd0, ALL, mk(0,1,2'b11,ALL), ALL, 64'h7F);
        issue("R5", 2'd0, 1'b1, 2'd1, ALL, ALL, mk(1,0,2'b11,ALL), 64'h80);
        issue("R5", 2'd1, 1'b1, 2'd2, ALL, ALL, NONE, 64'hFFFF_FFFF_FFFF_FFFF);
        // R6: supervisor field clear without virtualization
        issue("R6", 2'd0, 1'b0, 2'd0, ALL, NONE, mk(0,1,2'b11,ALL), 64'hC5);
        issue("R6", 2'd1, 1'b0, 2'd0, ALL, NONE, NONE, 64'hC6);
        // R3: invalidate field values and alternate code, isolation of bits
        issue("R3", 2'd0, 1'b1, 2'd2, mk(0,0,2'b01,0), mk(0,0,2'b10,0), mk(0,0,2'b11,0), 64'h100);
        issue("R3", 2'd0, 1'b1, 2'd3, mk(1,1,2'b00,ALL), ALL, ALL, 64'h101);
        issue("R3", 2'd0, 1'b0, 2'd1, mk(1,0,2'b11,ALL), ALL, ALL, 64'h102);
        issue("R3", 2'd0, 1'b0, 2'd0, mk(1,0,2'b00,0), mk(1,0,2'b00,0), mk(1,0,2'b00,0), 64'h103);
        // R10/R2: idle gap holds the verdict
        tag = "R10";
        repeat (4) @(negedge clk);
        // R9 and general mix
        for (int i = 0; i < 400; i++) begin
            logic [CFG_W-1:0] w0, w1, w2;
            w0 = {$urandom, $urandom}; w1 = {$urandom, $urandom}; w2 = {$urandom, $urandom};
            if ($urandom % 3 == 0) w0 = w0 | 64'hF0;
            issue("R9", 2'($urandom), 1'($urandom), 2'($urandom), w0, w1, w2, {$urandom, $urandom});
            if ($urandom % 4 == 0) begin
                tag = "R2";
                repeat (1 + $urandom % 3) @(negedge clk);
            end
        end
        // R1: reset mid-run clears the outputs
        @(negedge clk); tag = "R1"; rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule